// File: doc/BRIEF.md
# Dual Power-Up Configuration Loader

This block keeps two fixed default register images, a stand-in for one-time-programmable storage, and a bank of operating registers that the rest of the chip reads. When reset is released, the block copies one of the two images into the operating bank, one register per clock cycle. The image is chosen by the `sel_pin` input or by a host-owned selection bit. A second host-owned control bit decides which of these two sources applies. Both control bits clear on reset, so after reset the pin always decides.

Once the first load has finished, a host write port can overwrite any operating register and the control register. The host's values last only until the next reset, which reloads the selected default image. The block watches the effective selection. Whenever it differs from the image that was last loaded, it copies the new image while `busy` is high. It then raises `load_done` for one cycle, so that dependent logic can be reset after the reconfiguration.

The write port takes a write in every cycle in which `wr_valid` is high and never applies back-pressure. A write that cannot take effect is dropped. This happens while a copy is running and for an address outside the map. A dropped write is reported by a one-cycle `wr_err` pulse. `sel_pin` must be synchronous to `clk`.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_n` is low, after at least one clock edge: every operating register reads 0, `busy` is 1, `load_done` is 0, `wr_err` is 0, `src_is_reg` is 0 and `host_sel` is 0.
- R2: After reset is released, the image copy takes NUM_REGS rising edges. `load_done` is high in the cycle that follows the NUM_REGS-th edge, and `busy` is low from that cycle on.
- R3: Word k of image 0 is (11*k + 0x21) and word k of image 1 is (37*k + 0x5A), each truncated to DATA_W bits. A completed load leaves exactly these words in the operating registers, and `active_img` shows the loaded image.
- R4: When `src_is_reg` is 0, the level of `sel_pin` picks the image: 0 picks image 0 and 1 picks image 1.
- R5: The control register sits at address NUM_REGS. Data bit 0 sets the source (1 = host bit, 0 = pin) and data bit 1 is the host selection. While the source is the host bit, `sel_pin` has no effect.
- R6: When the block is idle and the effective selection starts to differ from `active_img`, a reload begins at the next rising edge. `load_done` appears NUM_REGS+1 cycles after the pin change, or after the cycle that follows the control write.
- R7: An idle write to an address below NUM_REGS replaces that register at the next edge and leaves all other registers as they were.
- R8: A write while `busy` is high changes nothing, including the control register. `wr_err` is then high for exactly one cycle, in the cycle after the write.
- R9: A write to an address above NUM_REGS changes nothing and gives a one-cycle `wr_err` pulse.
- R10: A reset discards host-written registers and control bits, and reloads the image that `sel_pin` picks.
- R11: A change of selection during a copy does not alter that copy. If the effective selection still differs once the copy is done, a second copy follows at once.
- R12: `load_done` is a single-cycle pulse, given once for every completed copy, in the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_pin | input | 1 | External image select |
| wr_valid | input | 1 | Host write request |
| wr_addr | input | ADDR_W | Write address (NUM_REGS = control register) |
| wr_data | input | DATA_W | Write data |
| wr_err | output | 1 | Pulse: previous write was dropped |
| busy | output | 1 | Image copy in progress |
| load_done | output | 1 | Pulse: a copy just finished |
| active_img | output | 1 | Image loaded by the latest copy |
| src_is_reg | output | 1 | Selection source (1 = host bit) |
| host_sel | output | 1 | Host selection bit |
| op_regs | output | NUM_REGS*DATA_W | Operating registers, register k at bits [k*DATA_W +: DATA_W] |

## Verification
The copy is started in four ways: by reset release with either pin level, by a pin edge with pin selection, by control writes that move the source to the host bit and back, and by a pin edge in the middle of a copy. Every completed copy is compared word by word against the image that the bench computed itself. This separates a wrong image choice from a wrong word order or a truncated copy. Writes are aimed at idle registers, at the control register during a copy, and at an unmapped address. These cases tell apart an accepted write, a write blocked by `busy` and a write rejected by address. A final reset after host writes shows that nothing the host wrote survives.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_LOAD = 1'b1
  } seq_state_e;

  // control register field positions
  localparam int CTRL_SRC_BIT = 0;
  localparam int CTRL_SEL_BIT = 1;

  // default image contents, computed rather than tabulated
  function automatic logic [31:0] dflt_word(input logic img, input int unsigned idx);
    if (img) return 32'(idx * 37 + 32'h5A);
    else     return 32'(idx * 11 + 32'h21);
  endfunction

endpackage

// File: rtl/cfgl_select.sv
module cfgl_select (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_pin,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_wdata,
  output logic       src_is_reg,
  output logic       host_sel,
  output logic       eff_sel
);
  import cfgl_pkg::*;

  logic src_q, sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (ctrl_we) begin
      src_q <= ctrl_wdata[CTRL_SRC_BIT];
      sel_q <= ctrl_wdata[CTRL_SEL_BIT];
    end
  end

  assign src_is_reg = src_q;
  assign host_sel   = sel_q;
  assign eff_sel    = src_q ? sel_q : sel_pin;

  // R10: control bits come out of reset on pin selection
  a_r10_pin_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!src_is_reg && !host_sel));

  // R5: control bits move only on a control write
  a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctrl_we)) |-> ($stable(src_is_reg) && $stable(host_sel)));

endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eff_sel,
  output logic             busy,
  output logic             load_done,
  output logic [IDX_W-1:0] copy_idx,
  output logic             active_img
);
  import cfgl_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             img_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_LOAD;
      idx_q   <= '0;
      img_q   <= eff_sel;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (eff_sel != img_q) begin
            state_q <= SEQ_LOAD;
            idx_q   <= '0;
            img_q   <= eff_sel;
          end
        end
        SEQ_LOAD: begin
          if (idx_q == LAST_IDX) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy       = (state_q == SEQ_LOAD);
  assign load_done  = done_q;
  assign copy_idx   = idx_q;
  assign active_img = img_q;

  // R12: completion pulse coincides with the end of busy
  a_r12_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> load_done);

  // R12: single-cycle pulse
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  // R11: the image being copied does not change mid-copy
  a_r11_img_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && busy && $past(busy)) |-> $stable(active_img));

  // R6: an idle block with a mismatched selection starts copying
  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (eff_sel != active_img)) |=> busy);

endmodule

// File: rtl/cfgl_regbank.sv
module cfgl_regbank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       copy_en,
  input  logic                       copy_img,
  input  logic [IDX_W-1:0]           copy_idx,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  import cfgl_pkg::*;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [31:0] IMG0 = dflt_word(1'b0, g);
    localparam logic [31:0] IMG1 = dflt_word(1'b1, g);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    logic [DATA_W-1:0] r_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (copy_en && copy_idx == MY_IDX) begin
        r_q <= copy_img ? IMG1[DATA_W-1:0] : IMG0[DATA_W-1:0];
      end else if (wr_en && wr_idx == MY_IDX) begin
        r_q <= wr_data;
      end
    end

    assign regs_flat[g*DATA_W +: DATA_W] = r_q;
  end

  // R8: the write decode never lets a host write meet a copy
  a_r8_no_write_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
    !(copy_en && wr_en));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS + 1),
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_pin,
  input  logic                       wr_valid,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       wr_err,
  output logic                       busy,
  output logic                       load_done,
  output logic                       active_img,
  output logic                       src_is_reg,
  output logic                       host_sel,
  output logic [NUM_REGS*DATA_W-1:0] op_regs
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

  logic             eff_sel;
  logic [IDX_W-1:0] copy_idx;
  logic             hit_bank, hit_ctrl, wr_ok, bank_we, ctrl_we, err_d;
  logic             err_q;

  always_comb begin
    hit_bank = (wr_addr < CTRL_ADDR);
    hit_ctrl = (wr_addr == CTRL_ADDR);
    wr_ok    = wr_valid && !busy;
    bank_we  = wr_ok && hit_bank;
    ctrl_we  = wr_ok && hit_ctrl;
    err_d    = wr_valid && (busy || !(hit_bank || hit_ctrl));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign wr_err = err_q;

  cfgl_select u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_pin    (sel_pin),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (wr_data[1:0]),
    .src_is_reg (src_is_reg),
    .host_sel   (host_sel),
    .eff_sel    (eff_sel)
  );

  cfgl_seq #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_sel    (eff_sel),
    .busy       (busy),
    .load_done  (load_done),
    .copy_idx   (copy_idx),
    .active_img (active_img)
  );

  cfgl_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .copy_en   (busy),
    .copy_img  (active_img),
    .copy_idx  (copy_idx),
    .wr_en     (bank_we),
    .wr_idx    (wr_addr[IDX_W-1:0]),
    .wr_data   (wr_data),
    .regs_flat (op_regs)
  );

  // R8: a write during a copy is reported
  a_r8_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> wr_err);

  // R9: an unmapped address is reported
  a_r9_addr_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr > CTRL_ADDR) |=> wr_err);

  // R8: the error flag only follows a request
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wr_err) |-> $past(wr_valid));

  // R7: an idle register write leaves the copy machinery alone
  a_r7_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !busy && wr_addr < CTRL_ADDR && eff_sel == active_img) |=> !busy);

endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  localparam int NR = 8;
  localparam int DW = 8;
  localparam int AW = $clog2(NR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_pin = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_err, busy, load_done, active_img, src_is_reg, host_sel;
  logic [NR*DW-1:0] op_regs;

  int nchk = 0;
  int nerr = 0;
  int exp_q[$];
  logic prev_done = 1'b0;

  always #5 clk = ~clk;

  cfg_loader #(.NUM_REGS(NR), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err), .busy(busy),
    .load_done(load_done), .active_img(active_img), .src_is_reg(src_is_reg),
    .host_sel(host_sel), .op_regs(op_regs)
  );

  function automatic logic [DW-1:0] img_word(input int img, input int k);
    int v;
    v = (img != 0) ? (37 * k + 'h5A) : (11 * k + 'h21);
    return DW'(v);
  endfunction

  function automatic logic [DW-1:0] reg_at(input int k);
    return op_regs[k*DW +: DW];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  // monitor: compares every completed copy with the queued expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && load_done)
        chk(1'b0, "R12", "load_done longer than one cycle", 1, 0);
      if (load_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12", "unexpected load_done", 1, 0);
        end else begin
          automatic int img = exp_q.pop_front();
          automatic bit ok = 1'b1;
          for (int k = 0; k < NR; k++)
            if (reg_at(k) !== img_word(img, k)) begin
              ok = 1'b0;
              chk(1'b0, "R3", $sformatf("image %0d word %0d", img, k),
                  int'(reg_at(k)), int'(img_word(img, k)));
            end
          if (ok) chk(1'b1, "R3", "image words", 0, 0);
          chk(active_img == img[0], "R3", "active_img", int'(active_img), img);
          chk(!busy, "R12", "busy low with load_done", int'(busy), 0);
        end
      end
    end
    prev_done = rst_n && load_done;
  end

  task automatic wait_done(input int already, input int exp, input string req);
    int n = already;
    do begin
      @(negedge clk);
      n++;
    end while (!load_done && n < 40);
    chk(n == exp, req, "cycles to load_done", n, exp);
  endtask

  task automatic do_write(input int addr, input int data);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = AW'(addr);
    wr_data  = DW'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic reset_check(input logic pin);
    @(negedge clk);
    rst_n = 1'b0;
    sel_pin = pin;
    repeat (3) @(negedge clk);
    chk(op_regs == '0, "R1", "regs in reset", int'(op_regs[31:0]), 0);
    chk(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
    chk(!load_done && !wr_err, "R1", "pulses in reset", int'({load_done, wr_err}), 0);
    chk(!src_is_reg && !host_sel, "R1", "control in reset",
        int'({src_is_reg, host_sel}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // reset with pin selecting image 1; write to control during the copy
    reset_check(1'b1);
    exp_q.push_back(1);
    rst_n = 1'b1;
    wr_valid = 1'b1; wr_addr = AW'(NR); wr_data = DW'(3);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(wr_err == 1'b1, "R8", "error on write during copy", int'(wr_err), 1);
    wait_done(1, NR, "R2");
    chk(!src_is_reg && !host_sel, "R8", "blocked control write",
        int'({src_is_reg, host_sel}), 0);
    chk(wr_err == 1'b0, "R8", "error pulse single", int'(wr_err), 0);

    // idle register write
    do_write(3, 'hA5);
    chk(reg_at(3) == 8'hA5, "R7", "written register", int'(reg_at(3)), 'hA5);
    chk(reg_at(2) == img_word(1, 2) && reg_at(4) == img_word(1, 4), "R7",
        "neighbours untouched", int'(reg_at(2)), int'(img_word(1, 2)));
    chk(!busy && !wr_err, "R7", "no copy, no error", int'({busy, wr_err}), 0);

    // pin change under pin selection
    @(negedge clk);
    sel_pin = 1'b0;
    exp_q.push_back(0);
    wait_done(0, NR + 1, "R6");
    chk(active_img == 1'b0, "R4", "pin 0 picks image 0", int'(active_img), 0);

    // move selection to the host bit, picking image 1
    do_write(NR, 3);
    exp_q.push_back(1);
    chk(src_is_reg && host_sel, "R5", "control bits", int'({src_is_reg, host_sel}), 3);
    wait_done(0, NR + 1, "R6");

    // pin toggles now ignored
    begin
      automatic bit saw_busy = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        sel_pin = ~sel_pin;
        if (busy) saw_busy = 1'b1;
      end
      @(negedge clk);
      sel_pin = 1'b1;
      @(negedge clk);
      chk(!saw_busy && !busy, "R5", "pin ignored under host source", int'(saw_busy), 0);
      chk(reg_at(5) == img_word(1, 5), "R5", "registers kept", int'(reg_at(5)),
          int'(img_word(1, 5)));
    end

    // host bit picks image 0
    do_write(NR, 1);
    exp_q.push_back(0);
    wait_done(0, NR + 1, "R6");

    // back to the pin (pin=1), change pin during the copy
    do_write(NR, 0);
    exp_q.push_back(1);
    exp_q.push_back(0);
    @(negedge clk);
    sel_pin = 1'b0;
    chk(busy == 1'b1, "R11", "copy running at pin change", int'(busy), 1);
    wait_done(1, NR + 1, "R11");
    wait_done(0, NR + 1, "R11");

    // unmapped address
    do_write(NR + 4, 'hFF);
    chk(wr_err == 1'b1, "R9", "error on bad address", int'(wr_err), 1);
    @(negedge clk);
    chk(wr_err == 1'b0, "R9", "error pulse single", int'(wr_err), 0);
    begin
      automatic bit same = 1'b1;
      for (int k = 0; k < NR; k++)
        if (reg_at(k) !== img_word(0, k)) same = 1'b0;
      chk(same && !busy && !src_is_reg, "R9", "nothing changed", int'(same), 1);
    end

    // host state then reset: everything reverts to pin and default image
    do_write(NR, 3);
    exp_q.push_back(1);
    wait_done(0, NR + 1, "R6");
    do_write(2, 'h77);
    chk(reg_at(2) == 8'h77, "R7", "written before reset", int'(reg_at(2)), 'h77);
    reset_check(1'b0);
    exp_q.push_back(0);
    rst_n = 1'b1;
    wait_done(0, NR, "R10");
    chk(reg_at(2) == img_word(0, 2), "R10", "host value discarded",
        int'(reg_at(2)), int'(img_word(0, 2)));
    chk(!src_is_reg && active_img == 1'b0, "R10", "pin selection restored",
        int'({src_is_reg, active_img}), 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R12", "every copy completed", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule